// File: doc/BRIEF.md
# Frame-Deferred USB Interrupt Status Unit

This unit sits beside the schedule engine of a USB host controller. Each time the engine finishes working on a transfer descriptor, it presents a one-cycle completion report. The report carries the descriptor's active, interrupt-on-completion and short-packet-detect flags, its stall and CRC/timeout error flags, the transfer type, the received byte count and the endpoint's maximum packet size. The unit turns each report into interrupt causes.

Causes are not posted at once. They collect in a pending bank for the whole frame and are moved into the host-visible status register on the end-of-frame strobe. There are three causes: completion, error and short packet. Each cause has its own enable bit. Software clears status bits by writing ones to them.

A level interrupt is driven by a two-state machine. In state IRQ_QUIET the output is low. Transition RAISE leads to IRQ_RAISED when any enabled status bit is set. Transition DROP returns to IRQ_QUIET once none is set.

The unit also flags, in the same cycle as the report, when a short packet ends a non-isochronous transfer set.

Top module: `fdi_status_top`

## Requirements
- R1: After reset the status register (offset 0x0) and enable register (offset 0x4) read 0, and `irq` is 0.
- R2: A report with `td_stall` or `td_crc_to` set creates an error cause, status bit 1. It reaches the status register only on the `frame_end` edge; status bits never become set on any other edge.
- R3: A report with `td_ioc`=1 and `td_active`=0 creates a completion cause, status bit 0, whatever the other flags are. `td_ioc`=1 with `td_active`=1 creates no completion cause.
- R4: A short packet is a report with `td_rx_len` < `td_max_len` and `td_xtype` not isochronous (code 3; codes 0, 1 and 2 are control, bulk and interrupt). A short packet with `td_spd`=1 creates a short-packet cause, status bit 2, and also a completion cause, status bit 0. An isochronous report never creates a short-packet cause.
- R5: `xfer_set_end` is 1 in the same cycle as a valid short-packet report, whether or not `td_spd` is set. It is 0 otherwise.
- R6: On a `frame_end` edge, every pending cause moves to status and the pending bank empties. A cause reported in the cycle of `frame_end` itself is kept pending for the next frame.
- R7: A write to offset 0x0 clears every status bit whose data bit is 1 and leaves the others. A cause committed on the same edge wins over the clear.
- R8: The enable register at offset 0x4 holds bit 0 (error enable), bit 2 (completion enable) and bit 3 (short-packet enable). Every other bit reads 0. The read of both registers is combinational on `reg_addr`.
- R9: `irq` is 1 in the cycle after the edge on which some status bit and its enable are both 1. It falls in the cycle after the edge on which no such pair remains.
- R10: A read of any address other than 0x0 and 0x4 returns 0, and a write there changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_end | input | 1 | End-of-frame strobe, one cycle |
| td_valid | input | 1 | Completion report present this cycle |
| td_active | input | 1 | Descriptor still active |
| td_ioc | input | 1 | Interrupt-on-completion flag |
| td_spd | input | 1 | Short-packet-detect flag |
| td_stall | input | 1 | Descriptor ended stalled |
| td_crc_to | input | 1 | Descriptor ended with CRC error or timeout |
| td_xtype | input | 2 | Transfer type: 0 control, 1 bulk, 2 interrupt, 3 isochronous |
| td_rx_len | input | LEN_W | Bytes received |
| td_max_len | input | LEN_W | Endpoint maximum packet size |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational |
| xfer_set_end | output | 1 | Short packet ends the transfer set |
| irq | output | 1 | Level interrupt |

## Verification
The results fall due at different cycles:

- `xfer_set_end` is due in the same cycle as its report, so the bench samples it one time unit after driving the inputs.
- A cause becomes readable in the cycle after the `frame_end` edge, and `irq` follows one edge later.
- Enable writes and status clears are readable in the cycle after their edge.

The bench drives every input at the falling edge and checks all outputs at that same point. It advances its own expected pending, status, enable and interrupt values only at each rising edge, which keeps every comparison at the cycle the requirements name.

// File: rtl/fdi_pkg.sv
package fdi_pkg;

    typedef enum logic [1:0] {
        XT_CTRL = 2'd0,
        XT_BULK = 2'd1,
        XT_INTR = 2'd2,
        XT_ISO  = 2'd3
    } fdi_xtype_e;

    // bit 2 short packet, bit 1 error, bit 0 completion
    typedef struct packed {
        logic short_pkt;
        logic err;
        logic done;
    } fdi_cause_t;

    localparam int CAUSE_W   = 3;
    localparam int IEN_ERR   = 0;
    localparam int IEN_DONE  = 2;
    localparam int IEN_SHORT = 3;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } fdi_irq_state_e;

endpackage

// File: rtl/fdi_td_classify.sv
module fdi_td_classify
    import fdi_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             td_valid,
    input  logic             td_active,
    input  logic             td_ioc,
    input  logic             td_spd,
    input  logic             td_stall,
    input  logic             td_crc_to,
    input  logic [1:0]       td_xtype,
    input  logic [LEN_W-1:0] td_rx_len,
    input  logic [LEN_W-1:0] td_max_len,
    output fdi_cause_t       ev,
    output logic             xfer_end
);

    logic short_len;
    logic sp_applies;
    logic short_hit;

    always_comb begin
        short_len   = td_rx_len < td_max_len;
        sp_applies  = fdi_xtype_e'(td_xtype) != XT_ISO;
        short_hit   = td_valid && sp_applies && short_len;
        xfer_end    = short_hit;
        ev.short_pkt = short_hit && td_spd;
        ev.err       = td_valid && (td_stall || td_crc_to);
        ev.done      = (td_valid && td_ioc && !td_active) || (short_hit && td_spd);
    end

    assert_iso_no_short_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (td_valid && td_xtype == 2'd3) |-> (!ev.short_pkt && !xfer_end));

endmodule

// File: rtl/fdi_pending.sv
module fdi_pending
    import fdi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_end,
    input  fdi_cause_t ev,
    output fdi_cause_t pend
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= '0;
        end else if (frame_end) begin
            pend <= ev;
        end else begin
            pend <= pend | ev;
        end
    end

    assert_pend_empty_after_eof_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && ev == '0) |=> (pend == '0));

    assert_pend_holdover_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> ((pend & $past(ev)) == $past(ev)));

endmodule

// File: rtl/fdi_regs.sv
module fdi_regs
    import fdi_pkg::*;
#(
    parameter int          DATA_W  = 8,
    parameter int          ADDR_W  = 4,
    parameter logic [ADDR_W-1:0] STS_OFS = 'h0,
    parameter logic [ADDR_W-1:0] IEN_OFS = 'h4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_end,
    input  fdi_cause_t        pend,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output fdi_cause_t        sts,
    output fdi_cause_t        en_mask
);

    localparam logic [DATA_W-1:0] IEN_KEEP =
        (DATA_W'(1) << IEN_ERR) | (DATA_W'(1) << IEN_DONE) | (DATA_W'(1) << IEN_SHORT);

    logic [DATA_W-1:0] ien;
    fdi_cause_t        sts_clr;
    fdi_cause_t        sts_set;

    always_comb begin
        sts_clr = (reg_wr && reg_addr == STS_OFS) ? fdi_cause_t'(reg_wdata[CAUSE_W-1:0]) : '0;
        sts_set = frame_end ? pend : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts <= '0;
            ien <= '0;
        end else begin
            sts <= (sts & ~sts_clr) | sts_set;
            if (reg_wr && reg_addr == IEN_OFS) begin
                ien <= reg_wdata & IEN_KEEP;
            end
        end
    end

    always_comb begin
        en_mask.err       = ien[IEN_ERR];
        en_mask.done      = ien[IEN_DONE];
        en_mask.short_pkt = ien[IEN_SHORT];
        if (reg_addr == STS_OFS) begin
            reg_rdata = {{(DATA_W-CAUSE_W){1'b0}}, sts};
        end else if (reg_addr == IEN_OFS) begin
            reg_rdata = ien;
        end else begin
            reg_rdata = '0;
        end
    end

    assert_sts_set_only_at_eof_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts & ~$past(sts)) != '0) |-> $past(frame_end));

    assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == STS_OFS && !frame_end)
        |=> ((sts & $past(reg_wdata[CAUSE_W-1:0])) == '0));

endmodule

// File: rtl/fdi_irq_fsm.sv
module fdi_irq_fsm
    import fdi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  fdi_cause_t sts,
    input  fdi_cause_t en_mask,
    output logic       irq
);

    fdi_irq_state_e state;
    fdi_irq_state_e state_nx;
    logic           cause_any;

    always_comb begin
        cause_any = |(sts & en_mask);
        state_nx  = state;
        unique case (state)
            IRQ_QUIET:  if (cause_any)  state_nx = IRQ_RAISED; // RAISE
            IRQ_RAISED: if (!cause_any) state_nx = IRQ_QUIET;  // DROP
            default:    state_nx = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= IRQ_QUIET;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        unique case (state)
            IRQ_QUIET:  irq = 1'b0;
            IRQ_RAISED: irq = 1'b1;
            default:    irq = 1'b0;
        endcase
    end

    assert_irq_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts & en_mask) != '0) |=> irq);

    assert_irq_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts & en_mask) == '0) |=> !irq);

endmodule

// File: rtl/fdi_status_top.sv
module fdi_status_top
    import fdi_pkg::*;
#(
    parameter int LEN_W  = 11,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_end,
    input  logic              td_valid,
    input  logic              td_active,
    input  logic              td_ioc,
    input  logic              td_spd,
    input  logic              td_stall,
    input  logic              td_crc_to,
    input  logic [1:0]        td_xtype,
    input  logic [LEN_W-1:0]  td_rx_len,
    input  logic [LEN_W-1:0]  td_max_len,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              xfer_set_end,
    output logic              irq
);

    fdi_cause_t ev;
    fdi_cause_t pend;
    fdi_cause_t sts;
    fdi_cause_t en_mask;

    fdi_td_classify #(.LEN_W(LEN_W)) u_classify (
        .clk        (clk),
        .rst_n      (rst_n),
        .td_valid   (td_valid),
        .td_active  (td_active),
        .td_ioc     (td_ioc),
        .td_spd     (td_spd),
        .td_stall   (td_stall),
        .td_crc_to  (td_crc_to),
        .td_xtype   (td_xtype),
        .td_rx_len  (td_rx_len),
        .td_max_len (td_max_len),
        .ev         (ev),
        .xfer_end   (xfer_set_end)
    );

    fdi_pending u_pending (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_end (frame_end),
        .ev        (ev),
        .pend      (pend)
    );

    fdi_regs #(
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .STS_OFS (ADDR_W'('h0)),
        .IEN_OFS (ADDR_W'('h4))
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_end (frame_end),
        .pend      (pend),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .sts       (sts),
        .en_mask   (en_mask)
    );

    fdi_irq_fsm u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .sts     (sts),
        .en_mask (en_mask),
        .irq     (irq)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (irq == 1'b0 || rst_n));

endmodule

// File: tb/sim_fdi_status_top.sv
`timescale 1ns/1ps
module sim_fdi_status_top;

    localparam int LEN_W  = 11;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_end = 1'b0;
    logic              td_valid = 1'b0, td_active = 1'b0, td_ioc = 1'b0, td_spd = 1'b0;
    logic              td_stall = 1'b0, td_crc_to = 1'b0;
    logic [1:0]        td_xtype = 2'd0;
    logic [LEN_W-1:0]  td_rx_len = '0, td_max_len = '0;
    logic              reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              xfer_set_end;
    logic              irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // expected state, built from the requirements
    logic [2:0] m_pend = '0;
    logic [2:0] m_sts  = '0;
    logic [7:0] m_en   = '0;
    logic       m_irq  = 1'b0;

    always #10 clk = ~clk;

    fdi_status_top #(.LEN_W(LEN_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_end(frame_end),
        .td_valid(td_valid), .td_active(td_active), .td_ioc(td_ioc), .td_spd(td_spd),
        .td_stall(td_stall), .td_crc_to(td_crc_to), .td_xtype(td_xtype),
        .td_rx_len(td_rx_len), .td_max_len(td_max_len),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .xfer_set_end(xfer_set_end), .irq(irq)
    );

    function automatic logic f_short();
        return td_valid && td_xtype != 2'd3 && (td_rx_len < td_max_len);
    endfunction

    // {short, err, done}
    function automatic logic [2:0] f_event();
        logic [2:0] e;
        e[2] = f_short() && td_spd;
        e[1] = td_valid && (td_stall || td_crc_to);
        e[0] = (td_valid && td_ioc && !td_active) || (f_short() && td_spd);
        return e;
    endfunction

    function automatic logic [2:0] f_mask(input logic [7:0] en);
        return {en[3], en[0], en[2]};
    endfunction

    function automatic logic [7:0] f_read(input logic [ADDR_W-1:0] a);
        if (a == 4'h0) return {5'd0, m_sts};
        if (a == 4'h4) return m_en;
        return 8'h00;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle_inputs();
        frame_end = 1'b0; td_valid = 1'b0; td_active = 1'b0; td_ioc = 1'b0;
        td_spd = 1'b0; td_stall = 1'b0; td_crc_to = 1'b0; td_xtype = 2'd0;
        td_rx_len = '0; td_max_len = '0; reg_wr = 1'b0; reg_wdata = '0;
    endtask

    // inputs are already set by the caller at a falling edge
    task automatic cycle(input string tag);
        logic [2:0] ev;
        logic [2:0] clr;
        #1;
        chk((reg_addr == 4'h0 || reg_addr == 4'h4) ? tag : "R10", reg_rdata, f_read(reg_addr));
        chk("R9 irq", irq, m_irq);
        chk("R5 xfer_set_end", xfer_set_end, f_short());
        @(posedge clk);
        ev    = f_event();
        clr   = (reg_wr && reg_addr == 4'h0) ? reg_wdata[2:0] : 3'd0;
        m_irq = |(m_sts & f_mask(m_en));
        m_sts = (m_sts & ~clr) | (frame_end ? m_pend : 3'd0);
        m_pend = frame_end ? ev : (m_pend | ev);
        if (reg_wr && reg_addr == 4'h4) m_en = reg_wdata & 8'h0D;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic td(input logic act, input logic ioc, input logic spd, input logic stl,
                      input logic crc, input logic [1:0] xt, input int rx, input int mx);
        td_valid = 1'b1; td_active = act; td_ioc = ioc; td_spd = spd;
        td_stall = stl; td_crc_to = crc; td_xtype = xt;
        td_rx_len = LEN_W'(rx); td_max_len = LEN_W'(mx);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        reg_addr = 4'h0; cycle("R1 status");
        reg_addr = 4'h4; cycle("R1 enable");

        // R8 enable write, unused bits dropped
        reg_wr = 1'b1; reg_addr = 4'h4; reg_wdata = 8'hFF; cycle("R8 write");
        reg_addr = 4'h4; cycle("R8 readback");
        // R10 write elsewhere does nothing
        reg_wr = 1'b1; reg_addr = 4'h8; reg_wdata = 8'hFF; cycle("R10");
        reg_addr = 4'h4; cycle("R10 enable intact R8");

        // R3 IOC completion deferred to frame end
        reg_addr = 4'h0; td(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 64, 64); cycle("R3 event");
        reg_addr = 4'h0; cycle("R3 not before eof");
        reg_addr = 4'h0; frame_end = 1'b1; cycle("R3 eof");
        reg_addr = 4'h0; cycle("R3 committed");
        reg_addr = 4'h0; cycle("R9 raised");
        // R3 active TD with IOC does nothing
        reg_wr = 1'b1; reg_addr = 4'h0; reg_wdata = 8'h07; cycle("R7 clear");
        reg_addr = 4'h0; td(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 8, 8); cycle("R3 active");
        reg_addr = 4'h0; frame_end = 1'b1; cycle("R3 eof active");
        reg_addr = 4'h0; cycle("R3 active no status");

        // R2 stall and CRC/timeout errors
        td(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2, 8, 8); cycle("R2 stall");
        reg_addr = 4'h0; frame_end = 1'b1; cycle("R2 eof");
        reg_addr = 4'h0; cycle("R2 err set");
        reg_wr = 1'b1; reg_addr = 4'h0; reg_wdata = 8'h02; cycle("R7 clear err");
        reg_addr = 4'h0;
        td(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 8, 8); cycle("R2 crc");
        reg_addr = 4'h0; cycle("R2 still pending");

        // R6 report in the frame_end cycle held over
        reg_addr = 4'h0; frame_end = 1'b1;
        td(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 4, 4); cycle("R6 eof with event");
        reg_wr = 1'b1; reg_addr = 4'h0; reg_wdata = 8'h07; cycle("R6 clear");
        reg_addr = 4'h0; cycle("R6 empty after clear");
        reg_addr = 4'h0; frame_end = 1'b1; cycle("R6 next eof");
        reg_addr = 4'h0; cycle("R6 held event committed");

        // R4 short packet, iso excluded, R5 without SPD
        reg_wr = 1'b1; reg_addr = 4'h0; reg_wdata = 8'h07; cycle("R7 clear all");
        td(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd3, 3, 64); cycle("R4 iso short");
        td(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 3, 64); cycle("R5 short no spd");
        td(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd2, 64, 64); cycle("R4 full length");
        reg_addr = 4'h0; frame_end = 1'b1; cycle("R4 eof none");
        reg_addr = 4'h0; cycle("R4 nothing set");
        td(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 0, 8); cycle("R4 ctrl short");
        reg_addr = 4'h0; frame_end = 1'b1; cycle("R4 eof short");
        reg_addr = 4'h0; cycle("R4 short and done set");

        // R7 commit wins over clear in the same edge
        td(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 8, 8); cycle("R7 err event");
        reg_wr = 1'b1; reg_addr = 4'h0; reg_wdata = 8'h07; frame_end = 1'b1; cycle("R7 clear+eof");
        reg_addr = 4'h0; cycle("R7 err survives");

        // R9 irq drops after enable removed
        reg_wr = 1'b1; reg_addr = 4'h4; reg_wdata = 8'h00; cycle("R9 disable");
        reg_addr = 4'h0; cycle("R9 falling");
        reg_addr = 4'h0; cycle("R9 low");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 2);
            reg_addr  = (r == 0) ? 4'h0 : (r == 1) ? 4'h4 : 4'(($urandom_range(0, 15)));
            reg_wr    = ($urandom_range(0, 9) == 0);
            reg_wdata = 8'($urandom());
            frame_end = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 1) == 1) begin
                td($urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1,
                   $urandom_range(0, 1) == 1, $urandom_range(0, 5) == 0,
                   $urandom_range(0, 5) == 0, 2'($urandom_range(0, 3)),
                   $urandom_range(0, 80), $urandom_range(0, 64));
            end
            cycle((reg_addr == 4'h4) ? "R8 random" : "R2 R3 R4 R6 R7 random");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule